// File: doc/BRIEF.md
# Asynchronous DRAM Strobe Controller

This block is the control logic of a small dynamic memory that is driven by active-low row and column strobes, an active-low write enable and one address bus shared between row and column. A synchronous core samples the strobe pins on a fast system clock, finds their edges and tells the strobe orderings apart. A row strobe falling with the column strobe high opens a row. Each column strobe fall then reads or writes one word of that row. A column strobe already low when the row strobe falls starts a refresh whose row comes from an internal counter. A row cycle with no column strobe is a refresh of the addressed row.

A register array stands in for the cell array. Refresh never changes stored data. It only reports the touched row on a one-cycle strobe. Read data follows extended-data-out rules: it stays driven after the column strobe rises. A burst-of-four option generates the three column addresses that follow the first one inside an aligned group of four.

Every pin change is seen at the next clock edge, and outputs change at that edge.

Top module: `dram_strobe_ctrl`

## Requirements
- R1: After reset `dout_en` and `rfsh_stb` are 0, and the refresh counter is 0, so the first counter refresh reports row 0.
- R2: The row is taken from `addr` at the clock that sees `ras_n` fall while `cas_n` is high. The column is taken from `addr` at the clock that sees `cas_n` fall. With `we_n` high, `dout` shows the word at that row and column and `dout_en` is 1 right after that clock.
- R3: A `cas_n` fall with `we_n` low stores `din` at the addressed location and leaves `dout_en` at 0 after that clock.
- R4: While `ras_n` stays low, further `cas_n` falls reach other columns of the same row. `addr` at those times selects only the column.
- R5: A row cycle with no `cas_n` fall gives a one-cycle `rfsh_stb` after the clock that sees `ras_n` rise, with `rfsh_row` equal to the latched row, and drives no data.
- R6: If `cas_n` is low when `ras_n` falls, `addr`, `din` and `we_n` are ignored. No word is written, `dout_en` stays 0, and `rfsh_stb` pulses with `rfsh_row` equal to the counter value.
- R7: The refresh counter advances by one after each counter refresh and wraps from 2^ADDR_W-1 to 0. Refreshes of an addressed row leave it unchanged.
- R8: With `nibble_mode` at 1, the k-th `cas_n` fall (k = 0..3) of a group reaches column (base & ~3) | ((base + k) & 3), where base is `addr` at the first fall. `addr` is ignored on the other three falls, and the fifth fall starts a new group from `addr`.
- R9: After a read, `dout_en` stays 1 and `dout` holds its value through the `cas_n` rise, until `ras_n` rises (then `dout_en` goes to 0) or the next `cas_n` fall.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System sampling clock |
| rst_n | input | 1 | Active-low reset |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write enable, active low |
| nibble_mode | input | 1 | 1 selects bursts of four internally generated columns |
| addr | input | ADDR_W | Shared row/column address |
| din | input | DATA_W | Write data |
| dout | output | DATA_W | Read data |
| dout_en | output | 1 | Read data is driven (0 stands for high impedance) |
| rfsh_stb | output | 1 | One-cycle pulse when a row has been refreshed |
| rfsh_row | output | ADDR_W | Row touched by the last refresh |

## Verification
The hardest case to reach from the pins is a counter refresh that would corrupt data if it were decoded wrongly. The column strobe has to fall while no row is open, and write enable, data and address must be set to values that would cause a visible write. The bench does this for more than one full counter lap, so the wrap shows up in the reported rows. Afterwards it reads back every location of the array and compares each word with its own model, which exposes any stray write.

// File: rtl/dram_strobe_pkg.sv
package dram_strobe_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_OPEN = 2'd1,
    ST_CBR  = 2'd2
  } strobe_st_t;
endpackage

// File: rtl/dram_strobe_decode.sv
module dram_strobe_decode
  import dram_strobe_pkg::*;
#(
  parameter int ADDR_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ras_n,
  input  logic              cas_n,
  input  logic              we_n,
  input  logic              nib_mode,
  input  logic [ADDR_W-1:0] addr,
  output logic [ADDR_W-1:0] row_q,
  output logic [ADDR_W-1:0] col_sel,
  output logic              ev_rd,
  output logic              ev_wr,
  output logic              ev_ras_rise,
  output logic              ev_cbr,
  output logic              ev_ror
);
  // group column k of a burst of four that started at base
  function automatic logic [ADDR_W-1:0] burst_col(input logic [ADDR_W-1:0] base,
                                                  input logic [1:0] k);
    logic [ADDR_W-1:0] grp_mask;
    grp_mask = ADDR_W'(3);
    return (base & ~grp_mask) | ((base + ADDR_W'(k)) & grp_mask);
  endfunction

  strobe_st_t        st_q;
  logic              ras_q, cas_q;
  logic              cas_seen_q;
  logic [1:0]        nib_cnt_q;
  logic [ADDR_W-1:0] nib_base_q;

  logic ev_ras_fall, ev_cas_fall, ev_open, ev_access;

  assign ev_ras_fall = ras_q & ~ras_n;
  assign ev_ras_rise = ~ras_q & ras_n;
  assign ev_cas_fall = cas_q & ~cas_n;
  assign ev_cbr      = (st_q == ST_IDLE) && ev_ras_fall && !cas_n;
  assign ev_open     = (st_q == ST_IDLE) && ev_ras_fall && cas_n;
  assign ev_access   = (st_q == ST_OPEN) && ev_cas_fall && !ras_n;
  assign ev_rd       = ev_access & we_n;
  assign ev_wr       = ev_access & ~we_n;
  assign ev_ror      = (st_q == ST_OPEN) && ev_ras_rise && !cas_seen_q;

  assign col_sel = (nib_mode && nib_cnt_q != 2'd0) ? burst_col(nib_base_q, nib_cnt_q) : addr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ras_q      <= 1'b1;
      cas_q      <= 1'b1;
      st_q       <= ST_IDLE;
      row_q      <= '0;
      cas_seen_q <= 1'b0;
      nib_cnt_q  <= 2'd0;
      nib_base_q <= '0;
    end else begin
      ras_q <= ras_n;
      cas_q <= cas_n;
      unique case (st_q)
        ST_IDLE: begin
          if (ev_cbr) begin
            st_q <= ST_CBR;
          end else if (ev_open) begin
            st_q       <= ST_OPEN;
            row_q      <= addr;
            cas_seen_q <= 1'b0;
            nib_cnt_q  <= 2'd0;
          end
        end
        ST_OPEN: begin
          if (ev_ras_rise) begin
            st_q <= ST_IDLE;
          end else if (ev_access) begin
            cas_seen_q <= 1'b1;
            if (nib_mode) begin
              if (nib_cnt_q == 2'd0) nib_base_q <= addr;
              nib_cnt_q <= nib_cnt_q + 2'd1;
            end else begin
              nib_cnt_q <= 2'd0;
            end
          end
        end
        ST_CBR: begin
          if (ev_ras_rise) st_q <= ST_IDLE;
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  // R8: the fourth access of a burst closes the group
  a_r8_burst_closes: assert property (@(posedge clk) disable iff (!rst_n)
    (nib_mode && ev_access && nib_cnt_q == 2'd3) |=> (nib_cnt_q == 2'd0));

  // R6: a counter refresh never starts an access
  a_r6_cbr_no_access: assert property (@(posedge clk) disable iff (!rst_n)
    ev_cbr |=> (st_q == ST_CBR) && !ev_access);
endmodule

// File: rtl/dram_refresh_counter.sv
module dram_refresh_counter #(
  parameter int ADDR_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              step_i,
  output logic [ADDR_W-1:0] ctr_o
);
  localparam int ROWS = 1 << ADDR_W;

  function automatic logic [ADDR_W-1:0] wrap_next(input logic [ADDR_W-1:0] v);
    return (v == ADDR_W'(ROWS - 1)) ? '0 : v + ADDR_W'(1);
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ctr_o <= '0;
    else if (step_i) ctr_o <= wrap_next(ctr_o);
  end

  // R7: the counter moves only on a counter refresh
  a_r7_ctr_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !step_i |=> $stable(ctr_o));

  a_r7_ctr_moves: assert property (@(posedge clk) disable iff (!rst_n)
    step_i |=> (ctr_o != $past(ctr_o)));
endmodule

// File: rtl/dram_cell_array.sv
module dram_cell_array #(
  parameter int ADDR_W = 3,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              wr_i,
  input  logic [ADDR_W-1:0] row_i,
  input  logic [ADDR_W-1:0] col_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o
);
  localparam int WORDS = 1 << (2 * ADDR_W);

  logic [DATA_W-1:0] cells_q [WORDS];
  logic [2*ADDR_W-1:0] idx;

  assign idx     = {row_i, col_i};
  assign rdata_o = cells_q[idx];

  always_ff @(posedge clk) begin
    if (wr_i) cells_q[idx] <= wdata_i;
  end
endmodule

// File: rtl/dram_strobe_ctrl.sv
module dram_strobe_ctrl #(
  parameter int ADDR_W = 3,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ras_n,
  input  logic              cas_n,
  input  logic              we_n,
  input  logic              nibble_mode,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] din,
  output logic [DATA_W-1:0] dout,
  output logic              dout_en,
  output logic              rfsh_stb,
  output logic [ADDR_W-1:0] rfsh_row
);
  logic [ADDR_W-1:0] row_q, col_sel, ctr;
  logic [DATA_W-1:0] rdata;
  logic ev_rd, ev_wr, ev_ras_rise, ev_cbr, ev_ror;

  dram_strobe_decode #(.ADDR_W(ADDR_W)) u_decode (
    .clk(clk), .rst_n(rst_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n),
    .nib_mode(nibble_mode), .addr(addr), .row_q(row_q), .col_sel(col_sel),
    .ev_rd(ev_rd), .ev_wr(ev_wr), .ev_ras_rise(ev_ras_rise),
    .ev_cbr(ev_cbr), .ev_ror(ev_ror)
  );

  dram_refresh_counter #(.ADDR_W(ADDR_W)) u_rctr (
    .clk(clk), .rst_n(rst_n), .step_i(ev_cbr), .ctr_o(ctr)
  );

  dram_cell_array #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_cells (
    .clk(clk), .wr_i(ev_wr), .row_i(row_q), .col_i(col_sel),
    .wdata_i(din), .rdata_o(rdata)
  );

  // extended-data-out latch: loaded by a read, dropped by a write or row close
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dout    <= '0;
      dout_en <= 1'b0;
    end else if (ev_rd) begin
      dout    <= rdata;
      dout_en <= 1'b1;
    end else if (ev_wr || ev_ras_rise) begin
      dout_en <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rfsh_stb <= 1'b0;
      rfsh_row <= '0;
    end else begin
      rfsh_stb <= ev_cbr | ev_ror;
      if (ev_cbr)      rfsh_row <= ctr;
      else if (ev_ror) rfsh_row <= row_q;
    end
  end

  // R3: a write leaves the output undriven
  a_r3_write_hides: assert property (@(posedge clk) disable iff (!rst_n)
    ev_wr |=> !dout_en);

  // R5: an access-free row cycle reports its own row
  a_r5_ror_row: assert property (@(posedge clk) disable iff (!rst_n)
    ev_ror |=> rfsh_stb && (rfsh_row == $past(row_q)));

  // R6: a counter refresh reports and drives nothing
  a_r6_cbr_report: assert property (@(posedge clk) disable iff (!rst_n)
    ev_cbr |=> rfsh_stb && !dout_en);

  // R9: driven data holds until a new access or the row closes
  a_r9_edo_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (dout_en && !ev_rd && !ev_wr && !ev_ras_rise) |=> dout_en && $stable(dout));
endmodule

// File: tb/dram_strobe_ctrl_tb_top.sv
module dram_strobe_ctrl_tb_top;
  localparam int CLK_P  = 10;
  localparam int ADDR_W = 3;
  localparam int DATA_W = 8;
  localparam int ROWS   = 1 << ADDR_W;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1, nibble_mode = 1'b0;
  logic [ADDR_W-1:0] addr = '0;
  logic [DATA_W-1:0] din = '0;
  logic [DATA_W-1:0] dout;
  logic dout_en, rfsh_stb;
  logic [ADDR_W-1:0] rfsh_row;

  int checks = 0, failures = 0;
  int cbr_exp = 0;
  bit done = 0;
  logic [DATA_W-1:0] model [ROWS*ROWS];

  always #(CLK_P/2) clk = ~clk;

  dram_strobe_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) dut_i (
    .clk(clk), .rst_n(rst_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n),
    .nibble_mode(nibble_mode), .addr(addr), .din(din), .dout(dout),
    .dout_en(dout_en), .rfsh_stb(rfsh_stb), .rfsh_row(rfsh_row)
  );

  function automatic logic [DATA_W-1:0] pattern(input int r, input int c, input int salt);
    return DATA_W'((r * 37 + c * 11 + salt * 59 + 5) % 256);
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic ras_open(input int r);
    addr = ADDR_W'(r); ras_n = 1'b0; tick();
  endtask

  task automatic ras_close(input bit expect_rfsh, input int r);
    ras_n = 1'b1; addr = ~addr; tick();
    chk("R9 close drops dout_en", dout_en, 0);
    chk("R5 refresh strobe on close", rfsh_stb, expect_rfsh);
    if (expect_rfsh) chk("R5 refreshed row", rfsh_row, r);
  endtask

  task automatic cas_write(input int r, input int c, input logic [DATA_W-1:0] d);
    addr = ADDR_W'(c); din = d; we_n = 1'b0; cas_n = 1'b0; tick();
    chk("R3 write keeps dout_en low", dout_en, 0);
    model[r*ROWS + c] = d;
    cas_n = 1'b1; we_n = 1'b1; din = ~d; tick();
  endtask

  task automatic cas_read(input string req, input int r, input int c, input int addr_drv);
    addr = ADDR_W'(addr_drv); we_n = 1'b1; cas_n = 1'b0; tick();
    chk({req, " dout_en"}, dout_en, 1);
    chk({req, " data"}, dout, model[r*ROWS + c]);
    cas_n = 1'b1; addr = ~addr; tick();
    chk("R9 hold after cas rise en", dout_en, 1);
    chk("R9 hold after cas rise data", dout, model[r*ROWS + c]);
  endtask

  task automatic cbr_cycle(input int salt);
    cas_n = 1'b0; tick();
    addr = ADDR_W'(salt); we_n = 1'b0; din = pattern(salt, salt, 7); ras_n = 1'b0; tick();
    chk("R6 cbr strobe", rfsh_stb, 1);
    chk("R7 cbr row from counter", rfsh_row, cbr_exp);
    chk("R6 cbr no output", dout_en, 0);
    cbr_exp = (cbr_exp + 1) % ROWS;
    cas_n = 1'b1; tick();
    chk("R6 cbr strobe single cycle", rfsh_stb, 0);
    ras_n = 1'b1; we_n = 1'b1; tick();
    chk("R6 no strobe at cbr close", rfsh_stb, 0);
  endtask

  initial begin
    #(CLK_P * 150000);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    tick(); tick();
    chk("R1 reset dout_en", dout_en, 0);
    chk("R1 reset rfsh_stb", rfsh_stb, 0);
    rst_n = 1'b1; tick();
    chk("R1 idle after reset", dout_en, 0);

    // R2/R3/R4: fill every location with page-mode writes
    for (int r = 0; r < ROWS; r++) begin
      ras_open(r);
      for (int c = 0; c < ROWS; c++) cas_write(r, c, pattern(r, c, 0));
      ras_close(1'b0, r);
    end

    // R2/R4/R9: page-mode reads in reversed column order
    for (int r = 0; r < ROWS; r++) begin
      ras_open(r);
      for (int c = ROWS - 1; c >= 0; c--) cas_read("R4 page read", r, c, c);
      ras_close(1'b0, r);
    end

    // R9: a second cas fall replaces the held word; a write drops it
    ras_open(2);
    cas_read("R2 read", 2, 5, 5);
    cas_read("R9 new column", 2, 1, 1);
    cas_write(2, 6, 8'hA5);
    chk("R3 dout_en stays low after write", dout_en, 0);
    cas_read("R3 readback", 2, 6, 6);
    ras_close(1'b0, 2);

    // R5: access-free row cycles, counter untouched
    for (int r = 0; r < ROWS; r += 3) begin
      ras_open(r);
      tick();
      ras_close(1'b1, r);
      tick();
      chk("R5 strobe single cycle", rfsh_stb, 0);
    end

    // R6/R7: more than one counter lap, with hostile pins
    for (int i = 0; i < ROWS + 3; i++) cbr_cycle(i);

    // R5 between counter refreshes must not move the counter
    ras_open(4); tick(); ras_close(1'b1, 4);
    cbr_cycle(1);

    // R8: bursts of four from several bases, bus scrambled after first
    nibble_mode = 1'b1;
    for (int b = 0; b < ROWS; b += 3) begin
      ras_open(b ^ 1);
      for (int k = 0; k < 4; k++) begin
        int c;
        c = (b & ~3) | ((b + k) & 3);
        cas_read("R8 burst", b ^ 1, c, (k == 0) ? b : (b + 5 * k + 1));
      end
      cas_read("R8 fifth pulse uses bus", b ^ 1, (b + 2) % ROWS, (b + 2) % ROWS);
      ras_close(1'b0, b ^ 1);
    end
    // R8 burst write then normal readback
    ras_open(3);
    for (int k = 0; k < 4; k++) begin
      int c;
      c = (6 & ~3) | ((6 + k) & 3);
      addr = ADDR_W'((k == 0) ? 6 : k); din = pattern(3, c, 3); we_n = 1'b0; cas_n = 1'b0; tick();
      chk("R8 burst write hides output", dout_en, 0);
      model[3*ROWS + c] = pattern(3, c, 3);
      cas_n = 1'b1; we_n = 1'b1; tick();
    end
    ras_close(1'b0, 3);
    nibble_mode = 1'b0;

    // R6: full readback proves no refresh wrote anything
    for (int r = 0; r < ROWS; r++) begin
      ras_open(r);
      for (int c = 0; c < ROWS; c++) cas_read("R6 data intact", r, c, c);
      ras_close(1'b0, r);
    end

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule